// File: doc/BRIEF.md
# Halt Power Mode Controller

This block sequences what happens when the processor issues a halt request. The moment the request arrives, it picks one of three outcomes. In a full-stop halt, every clock is gated and the main oscillator stops. In an oscillator-keeping halt, the main oscillator and its wake-up time base keep running while the processor and peripheral clocks are gated. If the watchdog is running and its option bit does not allow a halt, the halt is refused and a watchdog reset is requested instead.

While halted, only an external reset request or an interrupt line marked as halt-exit capable wakes the block. After a full-stop halt, the oscillator is switched back on at once. The processor and peripheral clocks stay gated until a settling counter has run through its whole period. After an oscillator-keeping halt, the clocks return on the cycle after the wake event. On the first running cycle after a wake, the block emits a wake indication. That indication selects either a reset-vector fetch or interrupt service, and the interrupt path also requests a push of the condition-code register.

Top module: `halt_power_ctrl`

## Requirements
- R1: A haltReq seen while running with oscIntEn=0, and without the watchdog refusal of R3, puts the block in full-stop halt from the next cycle. In that state oscEn, cpuClkEn and periphClkEn are all 0.
- R2: A haltReq seen while running with oscIntEn=1 puts the block in oscillator-keeping halt from the next cycle. In that state oscEn=1 while cpuClkEn=0 and periphClkEn=0.
- R3: A haltReq with oscIntEn=0, wdgEnable=1 and wdgHaltOpt=0 does not halt. wdgResetReq is 1 for exactly the next cycle, and the clocks keep running.
- R4: A haltReq with oscIntEn=1 never raises wdgResetReq, whatever the values of wdgEnable and wdgHaltOpt.
- R5: On entry to either halt, intMaskClr is 1 for exactly the first halted cycle.
- R6: While halted, the only wake events are extReset=1 or an irqLines bit i that is 1 while irqHaltWake bit i is 1. Any other interrupt line leaves the block halted. extReset has no effect while running.
- R7: After a wake from full-stop halt, oscEn is 1 from the next cycle. cpuClkEn and periphClkEn stay 0 for STAB_CYCLES-1 cycles (4095 by default) and become 1 in cycle STAB_CYCLES, when the 12-bit settle counter reaches its terminal count.
- R8: wakeValid is a one-cycle pulse on the first running cycle after any wake. In that cycle, wakeToReset=1 means reset-vector fetch and wakeToReset=0 means interrupt service. pushCc=1 only for an interrupt wake.
- R9: When extReset and a halt-exit interrupt arrive in the same cycle, the wake is taken as a reset wake (wakeToReset=1, pushCc=0).
- R10: A haltReq that arrives while halted or during the settle window is ignored. It neither extends nor restarts the sequence and does not pulse intMaskClr.
- R11: After a wake from oscillator-keeping halt, cpuClkEn, periphClkEn and wakeValid are 1 on the next cycle, with no settle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| haltReq | input | 1 | One-cycle halt strobe from the processor |
| oscIntEn | input | 1 | Oscillator interrupt enable; selects oscillator-keeping halt |
| wdgEnable | input | 1 | Watchdog is running |
| wdgHaltOpt | input | 1 | Option bit; 1 allows halt with the watchdog running |
| extReset | input | 1 | External reset request (wake source) |
| irqLines | input | NIRQ | Pending interrupt lines |
| irqHaltWake | input | NIRQ | Per-line halt-exit capability |
| cpuClkEn | output | 1 | Processor clock enable |
| oscEn | output | 1 | Main oscillator enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| wdgResetReq | output | 1 | Watchdog reset request pulse |
| intMaskClr | output | 1 | Pulse forcing the interrupt mask bit to 0 |
| wakeValid | output | 1 | Wake indication pulse |
| wakeToReset | output | 1 | 1: fetch reset vector; 0: service interrupt |
| pushCc | output | 1 | Push condition-code register before service |

## Verification
Several invariants are checked by the assertions on every cycle:
- the processor and peripheral clocks are never on while the oscillator is off;
- the two clock enables always move together;
- a restarting oscillator never comes up together with the processor clock;
- a watchdog request or a mask-clear pulse only ever follows a qualifying halt strobe;
- the wake and push pulses last one cycle and agree with each other.

Other behaviours need the bench's scenarios:
- the exact settle length;
- which interrupt lines count as wake sources;
- reset-over-interrupt priority;
- halt strobes that are ignored during halt and settling;
- the choice between the three outcomes across random option-bit combinations.

// File: rtl/halt_pm_pkg.sv
package halt_pm_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_HALT_STD = 2'd1,
    ST_HALT_ACT = 2'd2,
    ST_SETTLE   = 2'd3
  } pmState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClear;   // zero the settle counter (halt entry)
    logic cntRun;     // advance the settle counter
    logic causeLoad;  // capture the wake cause
  } dpCtrl_t;

endpackage

// File: rtl/halt_pm_datapath.sv
module halt_pm_datapath
  import halt_pm_pkg::*;
#(
  parameter int STAB_CYCLES = 4096,
  parameter int NIRQ        = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtrl_t         ctrl,
  input  logic            extReset,
  input  logic [NIRQ-1:0] irqLines,
  input  logic [NIRQ-1:0] irqHaltWake,
  output logic            wakeAny,
  output logic            stabDone,
  output logic            causeReset
);

  localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(STAB_CYCLES - 1);

  logic [CNT_W-1:0] settleCnt;
  logic [NIRQ-1:0]  hitVec;
  logic             irqWake;

  // Per-line halt-exit qualification
  for (genvar i = 0; i < NIRQ; i++) begin : g_hit
    assign hitVec[i] = irqLines[i] & irqHaltWake[i];
  end

  assign irqWake  = |hitVec;
  assign wakeAny  = extReset | irqWake;
  assign stabDone = (settleCnt == TERM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (ctrl.cntClear) begin
      settleCnt <= '0;
    end else if (ctrl.cntRun) begin
      settleCnt <= stabDone ? '0 : settleCnt + 1'b1;
    end
  end

  // Reset outranks an interrupt in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReset <= 1'b0;
    end else if (ctrl.causeLoad) begin
      causeReset <= extReset;
    end
  end

endmodule

// File: rtl/halt_pm_control.sv
module halt_pm_control
  import halt_pm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     haltReq,
  input  logic     oscIntEn,
  input  logic     wdgEnable,
  input  logic     wdgHaltOpt,
  input  logic     wakeAny,
  input  logic     stabDone,
  output dpCtrl_t  ctrl,
  output pmState_t state,
  output logic     wdgResetReq,
  output logic     intMaskClr,
  output logic     wakeValid,
  output logic     cpuClkEn,
  output logic     oscEn,
  output logic     periphClkEn
);

  pmState_t stateNext;
  logic     wdgNext;
  logic     maskNext;
  logic     wakeNext;

  always_comb begin
    stateNext = state;
    wdgNext   = 1'b0;
    maskNext  = 1'b0;
    wakeNext  = 1'b0;
    ctrl      = '0;
    unique case (state)
      ST_RUN: begin
        if (haltReq) begin
          if (oscIntEn) begin
            stateNext     = ST_HALT_ACT;
            maskNext      = 1'b1;
            ctrl.cntClear = 1'b1;
          end else if (wdgEnable && !wdgHaltOpt) begin
            wdgNext = 1'b1;
          end else begin
            stateNext     = ST_HALT_STD;
            maskNext      = 1'b1;
            ctrl.cntClear = 1'b1;
          end
        end
      end
      ST_HALT_STD: begin
        if (wakeAny) begin
          stateNext      = ST_SETTLE;
          ctrl.causeLoad = 1'b1;
        end
      end
      ST_HALT_ACT: begin
        if (wakeAny) begin
          stateNext      = ST_RUN;
          ctrl.causeLoad = 1'b1;
          wakeNext       = 1'b1;
        end
      end
      ST_SETTLE: begin
        ctrl.cntRun = 1'b1;
        if (stabDone) begin
          stateNext = ST_RUN;
          wakeNext  = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_RUN;
      wdgResetReq <= 1'b0;
      intMaskClr  <= 1'b0;
      wakeValid   <= 1'b0;
    end else begin
      state       <= stateNext;
      wdgResetReq <= wdgNext;
      intMaskClr  <= maskNext;
      wakeValid   <= wakeNext;
    end
  end

  assign oscEn       = (state != ST_HALT_STD);
  assign cpuClkEn    = (state == ST_RUN) || ((state == ST_SETTLE) && stabDone);
  assign periphClkEn = cpuClkEn;

endmodule

// File: rtl/halt_power_ctrl.sv
module halt_power_ctrl
  import halt_pm_pkg::*;
#(
  parameter int STAB_CYCLES = 4096,
  parameter int NIRQ        = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            haltReq,
  input  logic            oscIntEn,
  input  logic            wdgEnable,
  input  logic            wdgHaltOpt,
  input  logic            extReset,
  input  logic [NIRQ-1:0] irqLines,
  input  logic [NIRQ-1:0] irqHaltWake,
  output logic            cpuClkEn,
  output logic            oscEn,
  output logic            periphClkEn,
  output logic            wdgResetReq,
  output logic            intMaskClr,
  output logic            wakeValid,
  output logic            wakeToReset,
  output logic            pushCc
);

  dpCtrl_t  dpCtrl;
  pmState_t pmState;
  logic     wakeAny;
  logic     stabDone;
  logic     causeReset;

  halt_pm_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .haltReq     (haltReq),
    .oscIntEn    (oscIntEn),
    .wdgEnable   (wdgEnable),
    .wdgHaltOpt  (wdgHaltOpt),
    .wakeAny     (wakeAny),
    .stabDone    (stabDone),
    .ctrl        (dpCtrl),
    .state       (pmState),
    .wdgResetReq (wdgResetReq),
    .intMaskClr  (intMaskClr),
    .wakeValid   (wakeValid),
    .cpuClkEn    (cpuClkEn),
    .oscEn       (oscEn),
    .periphClkEn (periphClkEn)
  );

  halt_pm_datapath #(
    .STAB_CYCLES (STAB_CYCLES),
    .NIRQ        (NIRQ)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (dpCtrl),
    .extReset    (extReset),
    .irqLines    (irqLines),
    .irqHaltWake (irqHaltWake),
    .wakeAny     (wakeAny),
    .stabDone    (stabDone),
    .causeReset  (causeReset)
  );

  assign wakeToReset = wakeValid & causeReset;
  assign pushCc      = wakeValid & ~causeReset;

endmodule

// File: rtl/halt_pm_checker.sv
module halt_pm_checker (
  input logic clk,
  input logic rstN,
  input logic haltReq,
  input logic oscIntEn,
  input logic wdgEnable,
  input logic wdgHaltOpt,
  input logic cpuClkEn,
  input logic oscEn,
  input logic periphClkEn,
  input logic wdgResetReq,
  input logic intMaskClr,
  input logic wakeValid,
  input logic wakeToReset,
  input logic pushCc
);

  p_osc_off_gates_r1: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!cpuClkEn && !periphClkEn));

  p_clk_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn == periphClkEn);

  p_wdg_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    wdgResetReq |-> $past(haltReq && cpuClkEn && !oscIntEn && wdgEnable && !wdgHaltOpt));

  p_wdg_stays_running_r3: assert property (@(posedge clk) disable iff (!rstN)
    wdgResetReq |-> cpuClkEn);

  p_no_wdg_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && oscIntEn) |=> !wdgResetReq);

  p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    intMaskClr |-> (!cpuClkEn && $past(haltReq && cpuClkEn)));

  p_osc_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscEn) |-> !cpuClkEn);

  p_wake_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |=> !wakeValid);

  p_push_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    pushCc |-> (wakeValid && !wakeToReset));

  p_wake_running_r11: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |-> cpuClkEn);

endmodule

bind halt_power_ctrl halt_pm_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .haltReq     (haltReq),
  .oscIntEn    (oscIntEn),
  .wdgEnable   (wdgEnable),
  .wdgHaltOpt  (wdgHaltOpt),
  .cpuClkEn    (cpuClkEn),
  .oscEn       (oscEn),
  .periphClkEn (periphClkEn),
  .wdgResetReq (wdgResetReq),
  .intMaskClr  (intMaskClr),
  .wakeValid   (wakeValid),
  .wakeToReset (wakeToReset),
  .pushCc      (pushCc)
);

// File: tb/halt_power_ctrl_bench.sv
module halt_power_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NIRQ       = 8;
  localparam int STAB       = 4096;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            haltReq = 1'b0, oscIntEn = 1'b0, wdgEnable = 1'b0, wdgHaltOpt = 1'b0;
  logic            extReset = 1'b0;
  logic [NIRQ-1:0] irqLines = '0, irqHaltWake = '0;
  logic cpuClkEn, oscEn, periphClkEn, wdgResetReq, intMaskClr, wakeValid, wakeToReset, pushCc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  halt_power_ctrl #(.STAB_CYCLES(STAB), .NIRQ(NIRQ)) u_halt_power_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0: watchdog refusal, 1: full-stop halt, 2: oscillator-keeping halt
  function automatic int expMode(input bit oie, input bit wen, input bit wopt);
    if (oie) return 2;
    if (wen && !wopt) return 0;
    return 1;
  endfunction

  function automatic bit expToReset(input bit rst, input bit irqHit);
    return rst ? 1'b1 : (irqHit ? 1'b0 : 1'b1);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // wakeKind: 0 irq, 1 extReset, 2 both
  task automatic scenario(input bit oie, input bit wen, input bit wopt, input int wakeKind);
    int mode;
    logic [NIRQ-1:0] wakeMask, ignoredIrq, hitIrq;
    bit rstWake;
    mode = expMode(oie, wen, wopt);
    wakeMask = NIRQ'($urandom) | (NIRQ'(1) << ($urandom % NIRQ));
    ignoredIrq = ~wakeMask & NIRQ'($urandom);
    hitIrq = wakeMask & NIRQ'($urandom);
    if (hitIrq == '0) hitIrq = wakeMask & ~(wakeMask - 1'b1);
    oscIntEn = oie; wdgEnable = wen; wdgHaltOpt = wopt; irqHaltWake = wakeMask;
    haltReq = 1'b1;
    step();
    haltReq = 1'b0;
    if (mode == 0) begin
      chk("R3 wdgResetReq", wdgResetReq, 1);
      chk("R3 cpuClkEn kept", cpuClkEn, 1);
      chk("R5 no mask clear", intMaskClr, 0);
      step();
      chk("R3 one pulse", wdgResetReq, 0);
      return;
    end
    chk("R4 no wdg reset", wdgResetReq, 0);
    chk("R5 mask clear", intMaskClr, 1);
    chk(mode == 2 ? "R2 oscEn" : "R1 oscEn", oscEn, mode == 2);
    chk("R1 R2 cpuClkEn off", cpuClkEn, 0);
    chk("R1 R2 periphClkEn off", periphClkEn, 0);
    // ignored halt strobe and non-wake interrupts while halted
    haltReq = 1'b1; irqLines = ignoredIrq;
    step();
    haltReq = 1'b0;
    chk("R5 single mask pulse", intMaskClr, 0);
    step();
    irqLines = '0;
    chk("R6 R10 stays halted", cpuClkEn, 0);
    chk("R6 osc unchanged", oscEn, mode == 2);
    chk("R6 no wake", wakeValid, 0);
    // wake
    rstWake = (wakeKind != 0);
    extReset = rstWake;
    irqLines = (wakeKind != 1) ? hitIrq : '0;
    step();
    extReset = 1'b0; irqLines = '0;
    if (mode == 2) begin
      chk("R11 cpuClkEn", cpuClkEn, 1);
      chk("R11 wakeValid", wakeValid, 1);
      chk(wakeKind == 2 ? "R9 priority" : "R8 wakeToReset", wakeToReset,
          expToReset(rstWake, wakeKind != 1));
      chk("R8 pushCc", pushCc, !rstWake);
    end else begin
      chk("R7 oscEn restart", oscEn, 1);
      chk("R7 cpuClkEn held", cpuClkEn, 0);
      for (int i = 1; i <= STAB - 2; i++) begin
        haltReq = (i == 100);
        step();
      end
      haltReq = 1'b0;
      chk("R7 R10 still settling", cpuClkEn, 0);
      chk("R5 R10 no mask clear", intMaskClr, 0);
      step();
      chk("R7 cpuClkEn at terminal", cpuClkEn, 1);
      chk("R7 periphClkEn at terminal", periphClkEn, 1);
      chk("R8 no early wake", wakeValid, 0);
      step();
      chk("R8 wakeValid", wakeValid, 1);
      chk(wakeKind == 2 ? "R9 priority" : "R8 wakeToReset", wakeToReset,
          expToReset(rstWake, wakeKind != 1));
      chk("R8 pushCc", pushCc, !rstWake);
    end
    step();
    chk("R8 wake one pulse", wakeValid, 0);
    chk("R8 back running", cpuClkEn, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    step(); step();
    rstN = 1'b1;
    step();
    chk("R1 reset cpuClkEn", cpuClkEn, 1);
    chk("R1 reset oscEn", oscEn, 1);
    chk("R8 reset wakeValid", wakeValid, 0);
    chk("R3 reset wdgResetReq", wdgResetReq, 0);
    // extReset while running has no effect
    extReset = 1'b1;
    step();
    extReset = 1'b0;
    step();
    chk("R6 extReset in run", cpuClkEn, 1);
    chk("R6 extReset no wake", wakeValid, 0);
    // directed corners
    scenario(0, 0, 0, 0);
    scenario(0, 1, 1, 1);
    scenario(0, 0, 1, 2);
    scenario(1, 1, 0, 0);
    scenario(1, 0, 0, 1);
    scenario(1, 1, 1, 2);
    scenario(0, 1, 0, 0);
    // random mix
    for (int n = 0; n < 8; n++) begin
      scenario(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 3));
      step();
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule